// File: doc/BRIEF.md
# Target Buffer Update Sequencer

This block sits between the branch-resolution update channel and the storage bank of a set-associative branch target buffer. Each update carries the block start PC, a freshly built entry with its own valid bit, and two pieces of meta information captured when the prediction was made: whether the lookup hit and which way it hit in. The sequencer turns each accepted update into a single write on the bank's write port.

When the meta says the entry was already stored, the write goes straight to the recorded way in the same cycle the update is presented, with allocation off. When the meta says it was not stored, another update may have inserted the entry since the prediction. The sequencer therefore probes the bank through its update-read port and registers the result. It then writes either to the way the probe found or, if the probe also missed, with the allocate flag set so that the bank picks a victim. This miss path spans three cycles. The sequencer holds the PC and entry for the whole sequence and reports itself busy while a miss sequence is in flight.

Top module: `ftbu_update_seq`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it (even when a miss sequence was in flight), `busy`, `wr_valid`, `rd_req_valid` and `bank_access` are all 0 when no update is presented.
- R2: An accepted update with `upd_meta_hit`=1 drives, in the same cycle, `wr_valid`=1, `wr_alloc`=0, `wr_way`=`upd_meta_way`, `wr_pc`=`upd_pc` and `wr_data`=`upd_entry`. It raises neither `rd_req_valid` nor `bank_access`, and `busy` stays 0 afterwards.
- R3: An accepted update with `upd_meta_hit`=0 drives, in the same cycle, `rd_req_valid`=1 with `rd_req_pc`=`upd_pc` and `bank_access`=1, and drives no write.
- R4: For a miss-path update presented in cycle 0, the bank probe result (`rd_rsp_hit`, `rd_rsp_way`) is sampled only in cycle 1. The write is issued in cycle 2 and in no other cycle of the sequence.
- R5: If the sampled probe result hit, the cycle-2 write has `wr_alloc`=0 and `wr_way` equal to the sampled `rd_rsp_way`.
- R6: If the sampled probe result missed, the cycle-2 write has `wr_alloc`=1 and `wr_way`=0.
- R7: `busy` is 1 in cycles 1 and 2 of a miss sequence. Updates presented while `busy` is 1 produce no read request, no access indication and no write of their own.
- R8: The cycle-2 write carries the PC and entry presented in cycle 0, whatever is on the update inputs in cycles 1 and 2.
- R9: An update whose `upd_entry_vld` is 0 is ignored: no read request, no access indication, no write, and `busy` stays 0.
- R10: An update presented while `enable` is 0 is ignored in the same way as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Block enable; updates are ignored while 0 |
| upd_valid | input | 1 | Update request present |
| upd_pc | input | PC_W | Start PC of the updated block |
| upd_entry_vld | input | 1 | Valid bit of the new entry |
| upd_entry | input | ENTRY_W | New entry contents |
| upd_meta_hit | input | 1 | Prediction-time lookup hit |
| upd_meta_way | input | WAY_W | Prediction-time hit way |
| busy | output | 1 | Miss sequence in flight; new updates ignored |
| rd_req_valid | output | 1 | Bank update-read request |
| rd_req_pc | output | PC_W | PC for the bank update-read |
| bank_access | output | 1 | Update arrived with a meta miss |
| rd_rsp_hit | input | 1 | Bank probe hit, valid the cycle after the request |
| rd_rsp_way | input | WAY_W | Bank probe hit way |
| wr_valid | output | 1 | Bank write strobe |
| wr_pc | output | PC_W | Write PC (set index and tag source) |
| wr_data | output | ENTRY_W | Entry to write |
| wr_way | output | WAY_W | Way to write when not allocating |
| wr_alloc | output | 1 | Bank must choose the way |

## Verification
Meta-hit updates go to every way in turn, and each one shows whether the recorded way reaches the write port untouched and with no probe. Meta-miss updates are paired once with a probe hit and once with a probe miss. The probe inputs change in every cycle except the sampling one, and the update inputs carry a different PC during the busy cycles, which separates a correctly timed capture from one a cycle early or late. Requests with the entry invalid or the block disabled, a request in the cycle right after a write, a reset in the middle of a sequence, and a long random stream of mixed updates cover the acceptance conditions and the transitions back to idle.

// File: rtl/ftbu_pkg.sv
package ftbu_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_PROBE  = 2'd1,
    SEQ_COMMIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ftbu_seq_fsm.sv
// Tracks the three-cycle miss path: idle -> probe -> commit -> idle.
module ftbu_seq_fsm
  import ftbu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_miss,
  output logic in_probe,
  output logic in_commit,
  output logic busy
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE:   if (take_miss) state_d = SEQ_PROBE;
      SEQ_PROBE:  state_d = SEQ_COMMIT;
      SEQ_COMMIT: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign in_probe  = (state_q == SEQ_PROBE);
  assign in_commit = (state_q == SEQ_COMMIT);
  assign busy      = in_probe | in_commit;
endmodule

// File: rtl/ftbu_hold.sv
// Holding registers: request fields captured on acceptance, probe result
// captured in the probe cycle.
module ftbu_hold #(
  parameter int PC_W    = 41,
  parameter int ENTRY_W = 48,
  parameter int WAY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic [PC_W-1:0]    req_pc,
  input  logic [ENTRY_W-1:0] req_entry,
  input  logic               load_rsp,
  input  logic               rsp_hit,
  input  logic [WAY_W-1:0]   rsp_way,
  output logic [PC_W-1:0]    held_pc,
  output logic [ENTRY_W-1:0] held_entry,
  output logic               held_hit,
  output logic [WAY_W-1:0]   held_way
);
  logic [PC_W-1:0]    pc_d;
  logic [ENTRY_W-1:0] entry_d;
  logic               hit_d;
  logic [WAY_W-1:0]   way_d;

  always_comb begin
    pc_d    = held_pc;
    entry_d = held_entry;
    hit_d   = held_hit;
    way_d   = held_way;
    if (load_req) begin
      pc_d    = req_pc;
      entry_d = req_entry;
    end
    if (load_rsp) begin
      hit_d = rsp_hit;
      way_d = rsp_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_pc    <= '0;
      held_entry <= '0;
      held_hit   <= 1'b0;
      held_way   <= '0;
    end else begin
      held_pc    <= pc_d;
      held_entry <= entry_d;
      held_hit   <= hit_d;
      held_way   <= way_d;
    end
  end
endmodule

// File: rtl/ftbu_wr_sel.sv
// Write-port mux: direct (meta hit) write or the held miss-path write.
module ftbu_wr_sel #(
  parameter int PC_W    = 41,
  parameter int ENTRY_W = 48,
  parameter int WAY_W   = 2
) (
  input  logic               direct_en,
  input  logic [PC_W-1:0]    direct_pc,
  input  logic [ENTRY_W-1:0] direct_entry,
  input  logic [WAY_W-1:0]   direct_way,
  input  logic               commit_en,
  input  logic [PC_W-1:0]    held_pc,
  input  logic [ENTRY_W-1:0] held_entry,
  input  logic               held_hit,
  input  logic [WAY_W-1:0]   held_way,
  output logic               wr_valid,
  output logic [PC_W-1:0]    wr_pc,
  output logic [ENTRY_W-1:0] wr_data,
  output logic [WAY_W-1:0]   wr_way,
  output logic               wr_alloc
);
  always_comb begin
    wr_valid = 1'b0;
    wr_pc    = '0;
    wr_data  = '0;
    wr_way   = '0;
    wr_alloc = 1'b0;
    if (commit_en) begin
      wr_valid = 1'b1;
      wr_pc    = held_pc;
      wr_data  = held_entry;
      wr_alloc = !held_hit;
      wr_way   = held_hit ? held_way : '0;
    end else if (direct_en) begin
      wr_valid = 1'b1;
      wr_pc    = direct_pc;
      wr_data  = direct_entry;
      wr_way   = direct_way;
    end
  end
endmodule

// File: rtl/ftbu_update_seq.sv
module ftbu_update_seq #(
  parameter int PC_W     = 41,
  parameter int ENTRY_W  = 48,
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               upd_valid,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               upd_entry_vld,
  input  logic [ENTRY_W-1:0] upd_entry,
  input  logic               upd_meta_hit,
  input  logic [WAY_W-1:0]   upd_meta_way,
  output logic               busy,
  output logic               rd_req_valid,
  output logic [PC_W-1:0]    rd_req_pc,
  output logic               bank_access,
  input  logic               rd_rsp_hit,
  input  logic [WAY_W-1:0]   rd_rsp_way,
  output logic               wr_valid,
  output logic [PC_W-1:0]    wr_pc,
  output logic [ENTRY_W-1:0] wr_data,
  output logic [WAY_W-1:0]   wr_way,
  output logic               wr_alloc
);
  logic               accept, take_hit, take_miss;
  logic               in_probe, in_commit;
  logic [PC_W-1:0]    held_pc;
  logic [ENTRY_W-1:0] held_entry;
  logic               held_hit;
  logic [WAY_W-1:0]   held_way;

  assign accept    = upd_valid & enable & upd_entry_vld & ~busy;
  assign take_hit  = accept &  upd_meta_hit;
  assign take_miss = accept & ~upd_meta_hit;

  assign rd_req_valid = take_miss;
  assign rd_req_pc    = upd_pc;
  assign bank_access  = take_miss;

  ftbu_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_miss (take_miss),
    .in_probe  (in_probe),
    .in_commit (in_commit),
    .busy      (busy)
  );

  ftbu_hold #(.PC_W(PC_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (take_miss),
    .req_pc     (upd_pc),
    .req_entry  (upd_entry),
    .load_rsp   (in_probe),
    .rsp_hit    (rd_rsp_hit),
    .rsp_way    (rd_rsp_way),
    .held_pc    (held_pc),
    .held_entry (held_entry),
    .held_hit   (held_hit),
    .held_way   (held_way)
  );

  ftbu_wr_sel #(.PC_W(PC_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)) u_wr (
    .direct_en    (take_hit),
    .direct_pc    (upd_pc),
    .direct_entry (upd_entry),
    .direct_way   (upd_meta_way),
    .commit_en    (in_commit),
    .held_pc      (held_pc),
    .held_entry   (held_entry),
    .held_hit     (held_hit),
    .held_way     (held_way),
    .wr_valid     (wr_valid),
    .wr_pc        (wr_pc),
    .wr_data      (wr_data),
    .wr_way       (wr_way),
    .wr_alloc     (wr_alloc)
  );
endmodule

// File: rtl/ftbu_update_seq_chk.sv
module ftbu_update_seq_chk #(
  parameter int PC_W    = 41,
  parameter int ENTRY_W = 48,
  parameter int WAY_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               upd_valid,
  input logic [PC_W-1:0]    upd_pc,
  input logic               upd_entry_vld,
  input logic [ENTRY_W-1:0] upd_entry,
  input logic               upd_meta_hit,
  input logic [WAY_W-1:0]   upd_meta_way,
  input logic               busy,
  input logic               rd_req_valid,
  input logic [PC_W-1:0]    rd_req_pc,
  input logic               bank_access,
  input logic               rd_rsp_hit,
  input logic [WAY_W-1:0]   rd_rsp_way,
  input logic               wr_valid,
  input logic [PC_W-1:0]    wr_pc,
  input logic [ENTRY_W-1:0] wr_data,
  input logic [WAY_W-1:0]   wr_way,
  input logic               wr_alloc
);
  logic req_ok, req_hit, req_miss;
  assign req_ok   = upd_valid & enable & upd_entry_vld & ~busy;
  assign req_hit  = req_ok & upd_meta_hit;
  assign req_miss = req_ok & ~upd_meta_hit;

  assert_direct_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> (wr_valid && !wr_alloc && wr_way == upd_meta_way && !rd_req_valid && !bank_access));

  assert_probe_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_miss |-> (rd_req_valid && bank_access && rd_req_pc == upd_pc && !wr_valid));

  assert_write_third_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_miss |=> (busy && !wr_valid));

  assert_probe_hit_way_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_miss) && rd_rsp_hit) |=> (wr_valid && !wr_alloc && wr_way == $past(rd_rsp_way)));

  assert_probe_miss_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_miss) && !rd_rsp_hit) |=> (wr_valid && wr_alloc));

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rd_req_valid && !bank_access));

  assert_held_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_miss, 2) |-> (wr_pc == $past(upd_pc, 2) && wr_data == $past(upd_entry, 2)));

  assert_ignored_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !upd_entry_vld) |-> (!wr_valid && !rd_req_valid && !bank_access));

  assert_ignored_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !busy);
endmodule

bind ftbu_update_seq ftbu_update_seq_chk #(
  .PC_W(PC_W), .ENTRY_W(ENTRY_W), .WAY_W(WAY_W)
) u_chk (.*);

// File: tb/tb_ftbu_update_seq.sv
`timescale 1ns/1ps
module tb_ftbu_update_seq;
  localparam int PC_W     = 41;
  localparam int ENTRY_W  = 48;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               enable, upd_valid, upd_entry_vld, upd_meta_hit;
  logic [PC_W-1:0]    upd_pc;
  logic [ENTRY_W-1:0] upd_entry;
  logic [WAY_W-1:0]   upd_meta_way;
  logic               busy, rd_req_valid, bank_access, rd_rsp_hit;
  logic [PC_W-1:0]    rd_req_pc, wr_pc;
  logic [WAY_W-1:0]   rd_rsp_way, wr_way;
  logic               wr_valid, wr_alloc;
  logic [ENTRY_W-1:0] wr_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int               m_st = 0;
  logic [PC_W-1:0]    m_pc;
  logic [ENTRY_W-1:0] m_ent;
  bit               m_hit;
  int               m_way;

  always #4 clk = ~clk;

  ftbu_update_seq #(.PC_W(PC_W), .ENTRY_W(ENTRY_W), .NUM_WAYS(NUM_WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_entry_vld(upd_entry_vld), .upd_entry(upd_entry),
    .upd_meta_hit(upd_meta_hit), .upd_meta_way(upd_meta_way), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_pc(rd_req_pc), .bank_access(bank_access),
    .rd_rsp_hit(rd_rsp_hit), .rd_rsp_way(rd_rsp_way), .wr_valid(wr_valid),
    .wr_pc(wr_pc), .wr_data(wr_data), .wr_way(wr_way), .wr_alloc(wr_alloc)
  );

  task automatic cmp(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(input bit v, en, ev, mh, input int mw,
                       input logic [PC_W-1:0] pc, input logic [ENTRY_W-1:0] ent,
                       input bit rh, input int rw);
    upd_valid = v; enable = en; upd_entry_vld = ev; upd_meta_hit = mh;
    upd_meta_way = WAY_W'(mw); upd_pc = pc; upd_entry = ent;
    rd_rsp_hit = rh; rd_rsp_way = WAY_W'(rw);
  endtask

  task automatic step(input bit v, en, ev, mh, input int mw,
                      input logic [PC_W-1:0] pc, input logic [ENTRY_W-1:0] ent,
                      input bit rh, input int rw);
    bit acc;
    string t0;
    @(negedge clk);
    drive(v, en, ev, mh, mw, pc, ent, rh, rw);
    #2;
    acc = v && en && ev && (m_st == 0);
    if (m_st == 0) begin
      t0 = !v ? "R2" : (!en ? "R10" : (!ev ? "R9" : (mh ? "R2" : "R3")));
      cmp(t0, "busy", 64'(busy), 64'(0));
      cmp(t0, "rd_req_valid", 64'(rd_req_valid), 64'(acc && !mh));
      cmp(t0, "bank_access", 64'(bank_access), 64'(acc && !mh));
      cmp(t0, "wr_valid", 64'(wr_valid), 64'(acc && mh));
      if (acc && !mh) cmp("R3", "rd_req_pc", 64'(rd_req_pc), 64'(pc));
      if (acc && mh) begin
        cmp("R2", "wr_way", 64'(wr_way), 64'(mw));
        cmp("R2", "wr_alloc", 64'(wr_alloc), 64'(0));
        cmp("R2", "wr_pc", 64'(wr_pc), 64'(pc));
        cmp("R2", "wr_data", 64'(wr_data), 64'(ent));
      end
    end else begin
      cmp("R7", "busy", 64'(busy), 64'(1));
      cmp("R7", "rd_req_valid", 64'(rd_req_valid), 64'(0));
      cmp("R7", "bank_access", 64'(bank_access), 64'(0));
      cmp("R4", "wr_valid", 64'(wr_valid), 64'(m_st == 2));
      if (m_st == 2) begin
        cmp(m_hit ? "R5" : "R6", "wr_alloc", 64'(wr_alloc), 64'(!m_hit));
        cmp(m_hit ? "R5" : "R6", "wr_way", 64'(wr_way), 64'(m_hit ? m_way : 0));
        cmp("R8", "wr_pc", 64'(wr_pc), 64'(m_pc));
        cmp("R8", "wr_data", 64'(wr_data), 64'(m_ent));
      end
    end
    @(posedge clk);
    if (m_st == 1) begin
      m_hit = rh; m_way = rw; m_st = 2;
    end else if (m_st == 2) begin
      m_st = 0;
    end else if (acc && !mh) begin
      m_pc = pc; m_ent = ent; m_st = 1;
    end
  endtask

  task automatic reset_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst_n = 1'b0;
      drive(0, 1, 1, 0, 0, '0, '0, 0, 0);
      #2;
      cmp("R1", "busy", 64'(busy), 64'(0));
      cmp("R1", "wr_valid", 64'(wr_valid), 64'(0));
      cmp("R1", "rd_req_valid", 64'(rd_req_valid), 64'(0));
      cmp("R1", "bank_access", 64'(bank_access), 64'(0));
      m_st = 0;
    end
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    cmp("R1", "busy after release", 64'(busy), 64'(0));
    cmp("R1", "wr_valid after release", 64'(wr_valid), 64'(0));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 1, 1, 0, 0, '0, '0, 0, 0);
    reset_cycles(3);

    // R2: meta-hit writes to every way
    for (int w = 0; w < NUM_WAYS; w++)
      step(1, 1, 1, 1, w, 41'h100 + 41'(w * 64), 48'hA0000 + 48'(w), 0, 0);

    // R3 R4 R5 R7 R8: miss, probe hits way 2; intruding request during busy
    step(1, 1, 1, 0, 1, 41'h1_2345_6780, 48'hBEEF_0001, 0, 3);
    step(1, 1, 1, 1, 3, 41'h0_0000_0040, 48'h1111, 1, 2);
    step(1, 1, 1, 0, 0, 41'h0_0000_0080, 48'h2222, 0, 1);
    // request right after the write
    step(1, 1, 1, 1, 0, 41'h0_0000_00C0, 48'h3333, 1, 3);

    // R6: miss, probe misses -> allocate
    step(1, 1, 1, 0, 2, 41'h0_FFFF_0000, 48'hCAFE, 1, 1);
    step(0, 1, 1, 0, 0, '0, '0, 0, 3);
    step(0, 1, 1, 0, 0, '0, '0, 1, 2);

    // R9 and R10: ignored requests
    step(1, 1, 0, 0, 0, 41'h77, 48'h77, 0, 0);
    step(1, 1, 0, 1, 1, 41'h78, 48'h78, 0, 0);
    step(1, 0, 1, 0, 0, 41'h79, 48'h79, 0, 0);
    step(1, 0, 1, 1, 2, 41'h7A, 48'h7A, 0, 0);
    step(0, 1, 1, 0, 0, '0, '0, 0, 0);

    // R1: reset in the middle of a miss sequence
    step(1, 1, 1, 0, 0, 41'h5555, 48'h5555, 0, 0);
    reset_cycles(3);
    step(0, 1, 1, 0, 0, '0, '0, 0, 0);

    // mixed random stream
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0,
           $urandom % 2, $urandom % NUM_WAYS,
           PC_W'({$urandom, $urandom}), ENTRY_W'({$urandom, $urandom}),
           $urandom % 2, $urandom % NUM_WAYS);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule